// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block models the hit/miss behaviour of a set-associative cache. It keeps only tags and valid bits; there is no data array. Each request carries a physical address. The block cuts the address into a block offset, a set index and a tag, and compares the tag against every way of the indexed set. It answers with a hit flag and the way that was used.

On a miss the block installs the new tag. It fills the lowest-numbered empty way first. Only when the set is full does it ask the replacement policy for a victim. The policy is fixed at build time and is one of three: least recently used (per-set stamp counters with a minimum search), first-in first-out (per-set queue of way numbers) or pseudo-random (a 16-bit LFSR).

Two free-running counters count accepted requests and misses. The block takes one request per cycle. The answer appears in the next cycle.

Top module: `cache_tag_dir`

## Requirements
- R1: After reset `rsp_valid` is 0, both counters are 0 and every way of every set is empty, so the first access to any address misses.
- R2: With B-byte blocks and S sets, the low log2(B) address bits are the offset and are ignored for matching. The next log2(S) bits select the set. All higher bits form the tag. Two addresses in the same block hit each other; the same tag in another set does not.
- R3: A request is accepted in every cycle where `req_valid` is 1. In the following cycle `rsp_valid` is 1. `rsp_hit` is 1 exactly when a way of the indexed set is valid and holds the request tag, and `rsp_way` then names that way.
- R4: On a miss into a set that still has an empty way, the lowest-numbered empty way is filled and reported. Successive misses into an empty set therefore get ways 0, 1, 2 and so on.
- R5: With the LRU policy (POLICY = REPL_LRU, the default), a miss into a full set replaces the way whose last hit or fill is the oldest.
- R6: With the FIFO policy (POLICY = REPL_FIFO), a miss into a full set replaces the way that was filled earliest, and hits do not change this order.
- R7: With the random policy (POLICY = REPL_RAND), a miss into a full set replaces a way within 0..WAYS-1. The new tag then hits at that way, and the displaced tag misses.
- R8: `access_count` rises by one for every accepted request and `miss_count` by one for every miss. Both new values are visible in the cycle where that request's response is valid.
- R9: `req_ready` is always 1. In a cycle after one with `req_valid` at 0, `rsp_valid` is 0 and the counters do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Block can take a request (always 1) |
| req_addr | input | ADDR_W | Physical address of the request |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | 1 = tag was found, 0 = miss and install |
| rsp_way | output | log2(WAYS) | Way that hit or was filled |
| access_count | output | CNT_W | Number of accepted requests |
| miss_count | output | CNT_W | Number of misses |

## Verification
The hardest state to reach from the ports is a full set whose ways have been touched in a mixed order, because only there do the three policies choose different victims. The stimulus first fills one set directly. It then hits a middle way and forces a conflict. After that it runs a long random stream over just four sets and twelve tags per set, so every set overflows again and again with interleaved hits. Three instances, one per policy, see the same stream. A bench model of each policy predicts every response. For the random policy the model takes the victim way from the design's output and then checks that later hits and misses agree with it.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
   // replacement policy selected at build time
   typedef enum logic [1:0] {
      REPL_LRU  = 2'd0,
      REPL_FIFO = 2'd1,
      REPL_RAND = 2'd2
   } repl_e;
endpackage

// File: rtl/ctd_lookup.sv
// Parallel tag compare across one set, plus first-empty-way search.
module ctd_lookup #(
   parameter int WAYS   = 8,
   parameter int ADDR_W = 32,
   parameter int WAY_W  = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         check_en,
   input  logic [WAYS-1:0][ADDR_W-1:0]  row_tag,
   input  logic [WAYS-1:0]              row_valid,
   input  logic [ADDR_W-1:0]            key,
   output logic                         hit,
   output logic [WAY_W-1:0]             hit_way,
   output logic                         has_free,
   output logic [WAY_W-1:0]             free_way
);
   logic [WAYS-1:0] match;

   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = row_valid[g] && (row_tag[g] == key);
   end

   always_comb begin
      hit      = |match;
      has_free = ~&row_valid;
      hit_way  = '0;
      free_way = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (match[i])      hit_way  = WAY_W'(i);
         if (!row_valid[i]) free_way = WAY_W'(i);
      end
   end

   // R3
   one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      check_en |-> $onehot0(match));
endmodule

// File: rtl/ctd_repl.sv
// Replacement metadata and victim choice; one variant per policy.
module ctd_repl #(
   parameter cache_tag_pkg::repl_e POLICY = cache_tag_pkg::REPL_LRU,
   parameter int WAYS    = 8,
   parameter int SETS    = 32,
   parameter int WAY_W   = 3,
   parameter int IDX_W   = 5,
   parameter int STAMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic             miss,
   input  logic             conflict,
   input  logic [IDX_W-1:0] set_idx,
   input  logic [WAY_W-1:0] use_way,
   output logic [WAY_W-1:0] victim
);
   if (POLICY == cache_tag_pkg::REPL_LRU) begin : g_lru
      logic [STAMP_W-1:0] stamp [SETS][WAYS];
      logic [STAMP_W-1:0] gen   [SETS];
      logic [STAMP_W-1:0] best;
      logic               unused_lru;
      assign unused_lru = miss ^ conflict;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
               gen[s] <= '0;
               for (int w = 0; w < WAYS; w++) stamp[s][w] <= '0;
            end
         end else if (acc_en) begin
            stamp[set_idx][use_way] <= gen[set_idx];
            gen[set_idx]            <= gen[set_idx] + 1'b1;
         end
      end

      // strict compare: on equal stamps the lowest way is kept
      always_comb begin
         best   = stamp[set_idx][0];
         victim = '0;
         for (int i = 1; i < WAYS; i++) begin
            if (stamp[set_idx][i] < best) begin
               best   = stamp[set_idx][i];
               victim = WAY_W'(i);
            end
         end
      end
   end else if (POLICY == cache_tag_pkg::REPL_FIFO) begin : g_fifo
      logic [WAY_W-1:0] q  [SETS][WAYS];
      logic [WAY_W-1:0] rd [SETS];
      logic [WAY_W-1:0] wr [SETS];
      logic             unused_fifo;
      assign unused_fifo = acc_en;

      function automatic logic [WAY_W-1:0] bump(input logic [WAY_W-1:0] p);
         return (p == WAY_W'(WAYS - 1)) ? '0 : p + 1'b1;
      endfunction

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
               rd[s] <= '0;
               wr[s] <= '0;
               for (int w = 0; w < WAYS; w++) q[s][w] <= '0;
            end
         end else if (miss) begin
            q[set_idx][wr[set_idx]] <= use_way;
            wr[set_idx]             <= bump(wr[set_idx]);
            if (conflict) rd[set_idx] <= bump(rd[set_idx]);
         end
      end

      assign victim = q[set_idx][rd[set_idx]];

      // R6: a full set always has a full queue
      queue_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
         conflict |-> (rd[set_idx] == wr[set_idx]));
   end else begin : g_rand
      logic [15:0] lfsr;
      logic [15:0] pick;
      logic        fb;
      logic        unused_rand;
      assign unused_rand = miss ^ conflict ^ (^set_idx) ^ (^use_way);

      assign fb   = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
      assign pick = lfsr % 16'(WAYS);

      always_ff @(posedge clk) begin
         if (!rst_n)      lfsr <= 16'hACE1;
         else if (acc_en) lfsr <= {lfsr[14:0], fb};
      end

      assign victim = WAY_W'(pick);

      // R7
      lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lfsr != 16'd0);
   end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir #(
   parameter int ADDR_W    = 32,
   parameter int WAYS      = 8,
   parameter int BLK_BYTES = 64,
   parameter int SETS      = 32,
   parameter cache_tag_pkg::repl_e POLICY = cache_tag_pkg::REPL_LRU,
   parameter int STAMP_W   = 16,
   parameter int CNT_W     = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [ADDR_W-1:0]        req_addr,
   output logic                     rsp_valid,
   output logic                     rsp_hit,
   output logic [$clog2(WAYS)-1:0]  rsp_way,
   output logic [CNT_W-1:0]         access_count,
   output logic [CNT_W-1:0]         miss_count
);
   localparam int OFF_W = $clog2(BLK_BYTES);
   localparam int IDX_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam logic [ADDR_W-1:0] TAG_MASK = {ADDR_W{1'b1}} << (OFF_W + IDX_W);

   if (BLK_BYTES < 2 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : bad_blk
      $error("BLK_BYTES must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2) begin : bad_ways
      $error("WAYS must be at least 2");
   end
   if (ADDR_W <= OFF_W + IDX_W) begin : bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   logic [WAYS-1:0][ADDR_W-1:0] tag_mem [SETS];
   logic [WAYS-1:0]             vld_mem [SETS];

   logic             accept, hit, has_free, miss, conflict;
   logic [IDX_W-1:0] set_idx;
   logic [ADDR_W-1:0] key;
   logic [WAY_W-1:0] hit_way, free_way, victim, use_way;

   assign req_ready = 1'b1;
   assign accept    = req_valid;
   assign set_idx   = req_addr[OFF_W +: IDX_W];
   assign key       = req_addr & TAG_MASK;

   ctd_lookup #(.WAYS(WAYS), .ADDR_W(ADDR_W), .WAY_W(WAY_W)) u_lookup (
      .clk      (clk),
      .rst_n    (rst_n),
      .check_en (accept),
      .row_tag  (tag_mem[set_idx]),
      .row_valid(vld_mem[set_idx]),
      .key      (key),
      .hit      (hit),
      .hit_way  (hit_way),
      .has_free (has_free),
      .free_way (free_way)
   );

   assign miss     = accept && !hit;
   assign conflict = miss && !has_free;
   assign use_way  = hit ? hit_way : (has_free ? free_way : victim);

   ctd_repl #(
      .POLICY(POLICY), .WAYS(WAYS), .SETS(SETS),
      .WAY_W(WAY_W), .IDX_W(IDX_W), .STAMP_W(STAMP_W)
   ) u_repl (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_en  (accept),
      .miss    (miss),
      .conflict(conflict),
      .set_idx (set_idx),
      .use_way (use_way),
      .victim  (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_mem[s] <= '0;
            tag_mem[s] <= '0;
         end
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_way      <= '0;
         access_count <= '0;
         miss_count   <= '0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_hit      <= hit;
            rsp_way      <= use_way;
            access_count <= access_count + 1'b1;
            if (miss) begin
               miss_count                 <= miss_count + 1'b1;
               tag_mem[set_idx][use_way]  <= key;
               vld_mem[set_idx][use_way]  <= 1'b1;
            end
         end
      end
   end

   // R3
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && $stable(access_count) && $stable(miss_count)));

   // R8
   miss_le_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_count <= access_count);

   // R8
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (access_count == $past(access_count) + 1'b1));

   // R7
   way_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (32'(rsp_way) < WAYS));
endmodule

// File: tb/cache_tag_dir_tb.sv
module cache_tag_dir_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WAYS = 8;
   localparam int SETS = 32;
   localparam int NP   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [31:0] req_addr = '0;

   logic [NP-1:0]       r_ready, r_valid, r_hit;
   logic [NP-1:0][2:0]  r_way;
   logic [NP-1:0][31:0] acc, mis;

   int checks = 0;
   int errors = 0;

   int unsigned mt [NP][SETS][WAYS];
   bit          mv [NP][SETS][WAYS];
   int unsigned st [SETS][WAYS];
   int unsigned gn [SETS];
   int          fq [SETS][$];
   int unsigned macc;
   int unsigned mmiss [NP];

   always #(CLK_PERIOD/2) clk = ~clk;

   cache_tag_dir #(.POLICY(cache_tag_pkg::REPL_LRU)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r_ready[0]),
      .req_addr(req_addr), .rsp_valid(r_valid[0]), .rsp_hit(r_hit[0]),
      .rsp_way(r_way[0]), .access_count(acc[0]), .miss_count(mis[0]));

   cache_tag_dir #(.POLICY(cache_tag_pkg::REPL_FIFO)) u_fifo (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r_ready[1]),
      .req_addr(req_addr), .rsp_valid(r_valid[1]), .rsp_hit(r_hit[1]),
      .rsp_way(r_way[1]), .access_count(acc[1]), .miss_count(mis[1]));

   cache_tag_dir #(.POLICY(cache_tag_pkg::REPL_RAND)) u_rand (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r_ready[2]),
      .req_addr(req_addr), .rsp_valid(r_valid[2]), .rsp_hit(r_hit[2]),
      .rsp_way(r_way[2]), .access_count(acc[2]), .miss_count(mis[2]));

   task automatic chk(input bit ok, input string req, input int p,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s inst %0d actual %0h expected %0h", req, p, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int unsigned t, input int unsigned s,
                                      input int unsigned o);
      return (t << 11) | (s << 6) | (o & 63);
   endfunction

   task automatic access(input logic [31:0] a);
      int unsigned s, t;
      req_addr  = a;
      req_valid = 1'b1;
      @(negedge clk);
      macc++;
      s = (a >> 6) & 31;
      t = a >> 11;
      for (int p = 0; p < NP; p++) begin
         int hw, fw, ew;
         bit eh;
         string lbl;
         hw = -1;
         fw = -1;
         for (int w = WAYS - 1; w >= 0; w--) begin
            if (mv[p][s][w] && mt[p][s][w] == t) hw = w;
            if (!mv[p][s][w]) fw = w;
         end
         if (hw >= 0) begin
            eh = 1'b1; ew = hw; lbl = "R3";
         end else begin
            eh = 1'b0;
            mmiss[p]++;
            if (fw >= 0) begin
               ew = fw; lbl = "R4";
            end else if (p == 0) begin
               int unsigned b;
               ew = 0; b = st[s][0]; lbl = "R5";
               for (int w = 1; w < WAYS; w++)
                  if (st[s][w] < b) begin b = st[s][w]; ew = w; end
            end else if (p == 1) begin
               ew = fq[s].pop_front(); lbl = "R6";
            end else begin
               ew = int'(r_way[2]); lbl = "R7";
               chk(ew < WAYS, "R7", p, ew, WAYS - 1);
            end
            mt[p][s][ew] = t;
            mv[p][s][ew] = 1'b1;
            if (p == 1) fq[s].push_back(ew);
         end
         if (p == 0) begin
            st[s][ew] = gn[s];
            gn[s]++;
         end
         chk(r_valid[p] && (r_hit[p] == eh) && (int'(r_way[p]) == ew), lbl, p,
             {r_valid[p], r_hit[p], r_way[p]}, {1'b1, eh, 3'(ew)});
         chk(acc[p] == macc && mis[p] == mmiss[p], "R8", p,
             {acc[p], mis[p]}, {macc, mmiss[p]});
      end
   endtask

   task automatic idle_check;
      req_valid = 1'b0;
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
         chk(!r_valid[p] && acc[p] == macc && mis[p] == mmiss[p] && r_ready[p],
             "R9", p, {r_valid[p], acc[p]}, {1'b0, macc});
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      macc = 0;
      for (int p = 0; p < NP; p++) mmiss[p] = 0;
      for (int s = 0; s < SETS; s++) begin
         gn[s] = 0;
         for (int w = 0; w < WAYS; w++) begin
            st[s][w] = 0;
            for (int p = 0; p < NP; p++) begin mv[p][s][w] = 0; mt[p][s][w] = 0; end
         end
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int p = 0; p < NP; p++)
         chk(!r_valid[p] && acc[p] == 0 && mis[p] == 0 && r_ready[p], "R1", p,
             {r_valid[p], acc[p], mis[p]}, 0);
      // R1 / R4: fill set 1 in way order
      for (int t = 0; t < WAYS; t++) access(mk(t + 1, 1, t));
      // R2: other offset in the same block hits; same tag elsewhere misses
      access(mk(3, 1, 63));
      access(mk(3, 2, 0));
      // R5 / R6: touch way 0, then force a conflict in set 1
      access(mk(1, 1, 5));
      access(mk(20, 1, 0));
      access(mk(21, 1, 0));
      access(mk(1, 1, 0));
      idle_check();
      // mixed random stream over few sets and tags
      for (int n = 0; n < 3000; n++) begin
         access(mk($urandom_range(0, 11), $urandom_range(0, 3), $urandom_range(0, 63)));
         if ((n % 500) == 499) idle_check();
      end
      idle_check();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule